// File: doc/BRIEF.md
# Page-level recent bypass decision table

This block remembers, for a handful of recently seen pages, whether the last replacement decision taken for that page was to install the line or to bypass the cache. A DRAM cache controller queries it with the line address of a request that has just met a conflict. If the page is not in the table, the request is the page's representative. The per-line reuse policy then makes a fresh decision and updates its own state, and the controller writes that page and decision into the table. If the page is found, the request is a follower. It copies the remembered decision and the controller skips the per-line state update, which saves the DRAM bandwidth that the update would cost.

The table is fully associative. Each entry packs a valid bit, a page tag and one decision bit. The page number is the line address with its low in-page index bits removed (six bits for 64-line pages). New pages fill the slots in order. Once every slot is valid, a new page overwrites the slot that was filled longest ago, following a circular write pointer. Writing a page that is already present only changes its decision bit and leaves the pointer where it is. The lookup result is registered and appears one clock after the request.

Top module: `page_bypass_table`

## Requirements
- R1: After reset every entry is invalid, so each lookup misses until a page is inserted.
- R2: A lookup of a page that is not present returns hit_o=0, follow_o=0 and bypass_o=0 on the clock edge after the request.
- R3: A lookup of a page that is present returns hit_o=1 and follow_o=1, and bypass_o carries the stored decision (1 means bypass, 0 means install), on the clock edge after the request.
- R4: The page number is line_addr >> PAGE_IDX_W. Lines whose addresses differ only in the low PAGE_IDX_W bits match the same entry, and lines of neighbouring pages do not.
- R5: Inserting a page that is already present rewrites its decision bit in place. No new slot is allocated and the write pointer does not move.
- R6: Inserting a page that is absent writes the slot at the write pointer and advances the pointer circularly. With every slot valid, this evicts the page inserted longest ago among the pages still held.
- R7: When a lookup and an insert name the same page in one cycle, the insert wins. The response reports hit_o=1 with bypass_o equal to the insert's decision, and the table holds that decision afterwards.
- R8: rsp_valid_o is high exactly on the clock after a cycle with lk_valid high. While it is low, hit_o, follow_o and bypass_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_line_addr | input | LINE_W | Line address to look up |
| ins_valid | input | 1 | Insert strobe from the representative's decision |
| ins_line_addr | input | LINE_W | Line address of the representative |
| ins_bypass | input | 1 | Decision to remember: 1 bypass, 0 install |
| rsp_valid_o | output | 1 | Lookup response valid |
| hit_o | output | 1 | Page found in the table |
| bypass_o | output | 1 | Remembered decision for a hit |
| follow_o | output | 1 | Follower: suppress the per-line replacement-state update |

## Verification
Every lookup result is due on the first rising edge after the request cycle. An insert changes the table at that same edge, so a lookup issued in the next cycle already sees it. The bench drives each request on a falling edge and reads the response 1 ns after the following rising edge, before the next request is driven. The eviction and in-place update checks sweep every page of the small bench configuration after each change to the table, and compare the results with a slot-and-pointer model kept in the bench.

// File: rtl/pbt_pkg.sv
package pbt_pkg;

  // Registered lookup response
  typedef struct packed {
    logic valid;
    logic hit;
    logic bypass;
    logic follow;
  } pbt_rsp_t;

  localparam pbt_rsp_t PBT_RSP_IDLE = '{valid: 1'b0, hit: 1'b0, bypass: 1'b0, follow: 1'b0};

endpackage

// File: rtl/pbt_match.sv
// Associative compare of one key against every slot
module pbt_match #(
  parameter int ENTRIES = 128,
  parameter int TAG_W   = 30,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]            slot_vld,
  input  logic [ENTRIES-1:0][TAG_W-1:0] slot_tag,
  input  logic [ENTRIES-1:0]            slot_byp,
  input  logic [TAG_W-1:0]              key,
  output logic                          any_hit,
  output logic [IDX_W-1:0]              hit_idx,
  output logic                          hit_byp
);

  logic [ENTRIES-1:0] hv;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hv[g] = slot_vld[g] && (slot_tag[g] == key);
  end

  assign any_hit = |hv;
  assign hit_byp = |(hv & slot_byp);

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hv[i]) hit_idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/pbt_victim.sv
// Circular write pointer: next slot to allocate (oldest once full)
module pbt_victim #(
  parameter int ENTRIES = 128,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc,
  output logic [IDX_W-1:0] wr_ptr
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
    end else if (alloc) begin
      wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
    end
  end

endmodule

// File: rtl/page_bypass_table.sv
module page_bypass_table
  import pbt_pkg::*;
#(
  parameter int ENTRIES    = 128,
  parameter int LINE_W     = 36,
  parameter int PAGE_IDX_W = 6,
  localparam int TAG_W     = LINE_W - PAGE_IDX_W,
  localparam int IDX_W     = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [LINE_W-1:0] lk_line_addr,
  input  logic              ins_valid,
  input  logic [LINE_W-1:0] ins_line_addr,
  input  logic              ins_bypass,
  output logic              rsp_valid_o,
  output logic              hit_o,
  output logic              bypass_o,
  output logic              follow_o
);

  logic [ENTRIES-1:0]            vld_q;
  logic [ENTRIES-1:0][TAG_W-1:0] tag_q;
  logic [ENTRIES-1:0]            byp_q;

  logic [TAG_W-1:0] lk_page, ins_page;
  assign lk_page  = lk_line_addr[LINE_W-1:PAGE_IDX_W];
  assign ins_page = ins_line_addr[LINE_W-1:PAGE_IDX_W];

  logic             lk_hit, lk_byp;
  logic [IDX_W-1:0] lk_idx;
  logic             in_hit, in_byp;
  logic [IDX_W-1:0] in_idx;
  logic [IDX_W-1:0] wr_ptr;

  pbt_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_lk_match (
    .slot_vld (vld_q),
    .slot_tag (tag_q),
    .slot_byp (byp_q),
    .key      (lk_page),
    .any_hit  (lk_hit),
    .hit_idx  (lk_idx),
    .hit_byp  (lk_byp)
  );

  pbt_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_in_match (
    .slot_vld (vld_q),
    .slot_tag (tag_q),
    .slot_byp (byp_q),
    .key      (ins_page),
    .any_hit  (in_hit),
    .hit_idx  (in_idx),
    .hit_byp  (in_byp)
  );

  logic alloc;
  assign alloc = ins_valid && !in_hit;

  pbt_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk    (clk),
    .rst    (rst),
    .alloc  (alloc),
    .wr_ptr (wr_ptr)
  );

  logic [IDX_W-1:0] wr_idx;
  assign wr_idx = in_hit ? in_idx : wr_ptr;

  // Slot storage: one write port
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else if (ins_valid) begin
      vld_q[wr_idx] <= 1'b1;
      tag_q[wr_idx] <= ins_page;
      byp_q[wr_idx] <= ins_bypass;
    end
  end

  // Response: a same-page insert in this cycle overrides the stored state
  logic same_pg;
  assign same_pg = ins_valid && (ins_page == lk_page);

  pbt_rsp_t rsp_d, rsp_q;

  always_comb begin
    rsp_d = PBT_RSP_IDLE;
    if (lk_valid) begin
      rsp_d.valid = 1'b1;
      if (same_pg) begin
        rsp_d.hit    = 1'b1;
        rsp_d.bypass = ins_bypass;
      end else begin
        rsp_d.hit    = lk_hit;
        rsp_d.bypass = lk_hit && lk_byp;
      end
      rsp_d.follow = rsp_d.hit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rsp_q <= PBT_RSP_IDLE;
    else     rsp_q <= rsp_d;
  end

  assign rsp_valid_o = rsp_q.valid;
  assign hit_o       = rsp_q.hit;
  assign bypass_o    = rsp_q.bypass;
  assign follow_o    = rsp_q.follow;

  logic unused_idx;
  assign unused_idx = ^{lk_idx, in_byp};

endmodule

// File: rtl/page_bypass_table_chk.sv
module page_bypass_table_chk #(
  parameter int LINE_W     = 36,
  parameter int PAGE_IDX_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              lk_valid,
  input logic [LINE_W-1:0] lk_line_addr,
  input logic              ins_valid,
  input logic [LINE_W-1:0] ins_line_addr,
  input logic              ins_bypass,
  input logic              rsp_valid_o,
  input logic              hit_o,
  input logic              bypass_o,
  input logic              follow_o
);

  logic same_page;
  assign same_page = lk_line_addr[LINE_W-1:PAGE_IDX_W] == ins_line_addr[LINE_W-1:PAGE_IDX_W];

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> !rsp_valid_o && !hit_o);

  // R8
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_valid_o);

  // R8
  rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !rsp_valid_o && !hit_o && !follow_o && !bypass_o);

  // R2
  miss_no_bypass_chk: assert property (@(posedge clk) disable iff (rst)
    !hit_o |-> !bypass_o && !follow_o);

  // R7
  insert_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && ins_valid && same_page) |=> hit_o && (bypass_o == $past(ins_bypass)));

endmodule

bind page_bypass_table page_bypass_table_chk #(
  .LINE_W(LINE_W), .PAGE_IDX_W(PAGE_IDX_W)
) u_chk (.*);

// File: tb/page_bypass_table_test.sv
`timescale 1ns/1ps
module page_bypass_table_test;

  localparam int N   = 4;
  localparam int LW  = 12;
  localparam int OW  = 6;
  localparam int NPG = 1 << (LW - OW);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lk_valid = 1'b0, ins_valid = 1'b0, ins_bypass = 1'b0;
  logic [LW-1:0] lk_line_addr = '0, ins_line_addr = '0;
  logic rsp_valid_o, hit_o, bypass_o, follow_o;

  always #5 clk = ~clk;

  page_bypass_table #(.ENTRIES(N), .LINE_W(LW), .PAGE_IDX_W(OW)) uut (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_line_addr(lk_line_addr),
    .ins_valid(ins_valid), .ins_line_addr(ins_line_addr), .ins_bypass(ins_bypass),
    .rsp_valid_o(rsp_valid_o), .hit_o(hit_o), .bypass_o(bypass_o), .follow_o(follow_o)
  );

  int tests = 0, fails = 0;
  bit done = 0;

  // Reference model of slots and write pointer
  bit m_vld [N];
  int m_pg  [N];
  bit m_byp [N];
  int m_ptr = 0;

  function automatic void chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endfunction

  function automatic void m_insert(input int pg, input bit b);
    for (int i = 0; i < N; i++)
      if (m_vld[i] && m_pg[i] == pg) begin m_byp[i] = b; return; end
    m_vld[m_ptr] = 1; m_pg[m_ptr] = pg; m_byp[m_ptr] = b;
    m_ptr = (m_ptr + 1) % N;
  endfunction

  function automatic int m_lookup(input int pg);
    for (int i = 0; i < N; i++)
      if (m_vld[i] && m_pg[i] == pg) return 2 + int'(m_byp[i]);
    return 0;
  endfunction

  function automatic logic [LW-1:0] mk(input int pg, input int off);
    return LW'((pg << OW) | (off & ((1 << OW) - 1)));
  endfunction

  // Starts and ends just after a falling edge
  task automatic lookup(input int pg, input int off, input string req);
    int e;
    e = m_lookup(pg);
    lk_valid = 1; lk_line_addr = mk(pg, off);
    @(posedge clk); #1;
    chk({req, " valid"}, int'(rsp_valid_o), 1);
    chk({req, " hit"},   int'(hit_o),    e >= 2 ? 1 : 0);
    chk({req, " follow"},int'(follow_o), e >= 2 ? 1 : 0);
    chk({req, " bypass"},int'(bypass_o), e == 3 ? 1 : 0);
    @(negedge clk); lk_valid = 0;
  endtask

  task automatic insert(input int pg, input bit b);
    ins_valid = 1; ins_line_addr = mk(pg, pg * 7); ins_bypass = b;
    @(posedge clk); #1;
    chk("R8 idle during insert-only", int'(rsp_valid_o), 0);
    @(negedge clk); ins_valid = 0;
    m_insert(pg, b);
  endtask

  task automatic sweep(input string req);
    for (int p = 0; p < NPG; p++) lookup(p, p * 13, req);
  endtask

  task automatic both(input int pg, input bit b, input string req);
    lk_valid = 1; lk_line_addr = mk(pg, 1);
    ins_valid = 1; ins_line_addr = mk(pg, 40); ins_bypass = b;
    @(posedge clk); #1;
    chk({req, " hit"},    int'(hit_o), 1);
    chk({req, " bypass"}, int'(bypass_o), int'(b));
    @(negedge clk); lk_valid = 0; ins_valid = 0;
    m_insert(pg, b);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1; chk("R1 reset rsp_valid", int'(rsp_valid_o), 0);
    chk("R1 reset hit", int'(hit_o), 0);
    rst = 0;
    @(negedge clk);
    // R1 / R2: nothing present
    for (int p = 0; p < 8; p++) lookup(p, p, "R1 empty");
    @(posedge clk); #1; chk("R8 no request", int'(rsp_valid_o), 0);
    @(negedge clk);
    // R3 / R4: one page, all offsets and neighbours
    insert(3, 1'b1);
    lookup(3, 0, "R4 low offset");
    lookup(3, 63, "R4 high offset");
    lookup(2, 63, "R4 page below");
    lookup(4, 0, "R4 page above");
    // R3 fill and sweep
    insert(10, 1'b0); insert(20, 1'b1); insert(30, 1'b0);
    sweep("R3 full table");
    // R6 eviction of oldest
    insert(40, 1'b1);
    sweep("R6 first eviction");
    // R5 in place rewrite, then R6 next eviction
    insert(20, 1'b0);
    sweep("R5 rewrite");
    insert(50, 1'b1);
    sweep("R6 after rewrite");
    // R7 simultaneous lookup and insert
    both(60, 1'b1, "R7 absent page");
    both(40, 1'b0, "R7 present page");
    sweep("R7 table after");
    // R1 again: reset empties everything
    rst = 1; @(negedge clk); rst = 0;
    for (int i = 0; i < N; i++) m_vld[i] = 0;
    m_ptr = 0;
    sweep("R1 after reset");
    done = 1;
    finish_run();
  end

endmodule